// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives a multiplexed analog-to-digital converter through a sequence of conversions and keeps the results in eight result registers. Software writes one control word. The word holds a three-bit starting channel, a length select for four or eight conversions, a flag that chooses one channel or a run of consecutive channels, and a flag that chooses one pass or passes that repeat without end. The block then requests each conversion through a start/done/data handshake. It stores conversion k of a pass in result register k. It raises one completion flag for each register and one flag for the whole sequence.

A new control write cancels whatever is running and restarts from register 0 with every flag cleared. This is also how a continuous scan is stopped: write a one-shot control word. Results are read through a combinational read port. Reading a register leaves its flag unchanged.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, conv_start, every bit of reg_flag and seq_done are 0, and every result register reads 0.
- R2: A cycle with ctl_wr high clears reg_flag and seq_done and abandons any conversion in progress. conv_start is then high in the next cycle and requests conversion 0 of the new sequence.
- R3: ctl_wdata[2:0] is the start channel, bit 3 selects eight conversions (1) or four (0), bit 4 selects sequential channels (1) or a single channel (0), and bit 5 selects continuous scanning (1) or one pass (0). The mode number is {bit5, bit4, bit3}.
- R4: In the single-channel modes, every conversion requests conv_chan equal to the start channel.
- R5: In the sequential-channel modes, conversion k of every pass requests conv_chan = (start channel + k) mod 8.
- R6: The conv_data that comes with the done of conversion k is stored in result register k. Later passes overwrite the earlier results, and rd_data shows result register rd_addr in the same cycle.
- R7: reg_flag[k] is set on the clock edge where result register k is written, so the flags fill from bit 0 upward. Only a control write clears them, and reading does not.
- R8: In one-shot modes, seq_done rises on the edge that stores the last conversion. busy then falls and no more conversions are requested.
- R9: In continuous modes, seq_done rises at the end of the first full pass and stays high. Conversion 0 of the next pass is requested in the cycle after that.
- R10: conv_start is a single-cycle pulse. conv_done is taken only while a requested conversion is outstanding, and it is ignored at other times. After a done is accepted, the next request (if any) comes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word {scan, multi, len8, start channel[2:0]} |
| rd_addr | input | 3 | Result register read address |
| rd_data | output | DW | Contents of result register rd_addr |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_done | input | 1 | Converter finished a conversion |
| conv_data | input | DW | Converter result, valid with conv_done |
| reg_flag | output | 8 | Per-register conversion-complete flags |
| seq_done | output | 1 | Sequence-complete flag |
| busy | output | 1 | A sequence is running |

## Verification
The assertions assume the converter answers each request with exactly one conv_done pulse. They also assume it withdraws a pending answer when a control write cancels the request. Because of this, the pulse ordering and the flag properties only have to deal with dones that belong to the conversion currently outstanding. The bench converter waits a varying one to three cycles after each request and drops its pending answer whenever ctl_wr is seen. It only injects a stray conv_done while the block is idle, so the ignore rule is exercised without breaking that assumption.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [5:0]    ctl_wdata,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          conv_start,
  output logic [2:0]    conv_chan,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic [7:0]    reg_flag,
  output logic          seq_done,
  output logic          busy
);

  logic [2:0]    start_ch;
  logic          len8, multi, scan;
  logic [2:0]    idx;
  logic          req;
  logic [DW-1:0] res [8];
  logic [2:0]    last_idx;

  assign last_idx   = len8 ? 3'd7 : 3'd3;
  assign conv_start = req;
  assign conv_chan  = multi ? start_ch + idx : start_ch;
  assign rd_data    = res[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ch <= '0;
      len8     <= 1'b0;
      multi    <= 1'b0;
      scan     <= 1'b0;
      idx      <= '0;
      req      <= 1'b0;
      busy     <= 1'b0;
      reg_flag <= '0;
      seq_done <= 1'b0;
      for (int i = 0; i < 8; i++) res[i] <= '0;
    end else if (ctl_wr) begin
      start_ch <= ctl_wdata[2:0];
      len8     <= ctl_wdata[3];
      multi    <= ctl_wdata[4];
      scan     <= ctl_wdata[5];
      idx      <= '0;
      req      <= 1'b1;
      busy     <= 1'b1;
      reg_flag <= '0;
      seq_done <= 1'b0;
    end else if (req) begin
      req <= 1'b0;
    end else if (busy && conv_done) begin
      res[idx]      <= conv_data;
      reg_flag[idx] <= 1'b1;
      if (idx == last_idx) begin
        seq_done <= 1'b1;
        idx      <= '0;
        req      <= scan;
        busy     <= scan;
      end else begin
        idx <= idx + 3'd1;
        req <= 1'b1;
      end
    end
  end

endmodule

module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       conv_start,
  input logic [7:0] reg_flag,
  input logic       seq_done,
  input logic       busy
);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) conv_start |=> !conv_start); // R10
  AST_FLAGS_ORDERED: assert property (@(posedge clk) disable iff (!rst_n) (reg_flag & (reg_flag + 8'd1)) == 8'd0); // R7
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> (reg_flag == 8'd0 && !seq_done && conv_start)); // R2
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !ctl_wr |=> ((reg_flag & $past(reg_flag)) == $past(reg_flag))); // R7
  AST_DONE_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n) seq_done |-> (reg_flag[3:0] == 4'hF)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (seq_done && !ctl_wr) |=> seq_done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !conv_start); // R8

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .conv_start(conv_start),
  .reg_flag(reg_flag), .seq_done(seq_done), .busy(busy)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int DW = 10;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ctl_wr = 0;
  logic [5:0]    ctl_wdata = 0;
  logic [2:0]    rd_addr = 0;
  logic [DW-1:0] rd_data;
  logic          conv_start;
  logic [2:0]    conv_chan;
  logic          conv_done = 0;
  logic [DW-1:0] conv_data = 0;
  logic [7:0]    reg_flag;
  logic          seq_done;
  logic          busy;

  adc_seq_ctrl #(.DW(DW)) u_adc_seq_ctrl (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done_rep = 0;

  // reference model state
  int m_start = 0, m_len = 4, m_n = 0;
  bit m_multi = 0, m_scan = 0, m_run = 0, m_want = 0, m_wait = 0, m_done = 0;
  bit [7:0] m_flag = 0;
  logic [DW-1:0] m_res [8];

  // converter model state
  bit seen_start = 0, seen_wr = 0, stray = 0;
  int seen_chan = 0, cnt = 0, lat_sel = 0, job_chan = 0, serial = 1;

  task automatic report;
    if (!done_rep) begin
      done_rep = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    seen_start = conv_start;
    seen_chan  = conv_chan;
    seen_wr    = ctl_wr;
    if (!rst_n) begin
      m_run = 0; m_want = 0; m_wait = 0; m_done = 0; m_flag = 0; m_n = 0;
      for (int i = 0; i < 8; i++) m_res[i] = 0;
    end else if (ctl_wr) begin
      m_start = ctl_wdata[2:0];
      m_len   = ctl_wdata[3] ? 8 : 4;
      m_multi = ctl_wdata[4];
      m_scan  = ctl_wdata[5];
      m_flag = 0; m_done = 0; m_n = 0; m_run = 1; m_want = 1; m_wait = 0;
    end else if (m_want) begin
      m_want = 0; m_wait = 1;
    end else if (m_wait && conv_done) begin
      m_res[m_n] = conv_data;
      m_flag[m_n] = 1;
      m_wait = 0;
      if (m_n == m_len - 1) begin
        m_done = 1; m_n = 0;
        if (m_scan) m_want = 1; else m_run = 0;
      end else begin
        m_n++; m_want = 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
    conv_done = 0;
    if (seen_wr) cnt = 0;
    else if (seen_start) begin
      cnt = 1 + (lat_sel % 3); lat_sel++; job_chan = seen_chan;
    end
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done = 1;
        conv_data = DW'((job_chan << 7) | (serial & 127));
        serial++;
      end
    end else if (stray && !busy) begin
      conv_done = 1; conv_data = 10'h3AA; stray = 0;
    end
    if (rst_n && cyc > 3) begin
      chk("R7 reg_flag", reg_flag, m_flag);
      chk(m_scan ? "R9 seq_done" : "R8 seq_done", seq_done, m_done);
      chk("R2 R10 conv_start", conv_start, m_want);
      chk("R8 busy", busy, m_run);
      if (conv_start)
        chk(m_multi ? "R3 R5 conv_chan" : "R3 R4 conv_chan", conv_chan,
            m_multi ? (m_start + m_n) % 8 : m_start);
      chk("R6 rd_data", rd_data, m_res[rd_addr]);
    end
    rd_addr = rd_addr + 3'd3;
  end

  task automatic write_ctl(input bit scan, input bit multi, input bit l8, input int ch);
    @(negedge clk);
    ctl_wr = 1; ctl_wdata = {scan, multi, l8, 3'(ch)};
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic wait_idle;
    while (busy || ctl_wr) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flags", reg_flag, 0);
    chk("R1 reset seq_done", seq_done, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset conv_start", conv_start, 0);
    chk("R1 reset rd_data", rd_data, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // one-shot modes 0..3
    write_ctl(0, 0, 0, 5); wait_idle();
    write_ctl(0, 0, 1, 2); wait_idle();
    write_ctl(0, 1, 0, 6); wait_idle();
    write_ctl(0, 1, 1, 3); wait_idle();
    chk("R8 flags full after one-shot", reg_flag, 8'hFF);
    // stray done while idle is ignored (R10)
    stray = 1;
    repeat (4) @(negedge clk);
    chk("R10 stray done ignored", reg_flag, 8'hFF);
    // continuous modes 4..7, stopped by a one-shot write
    write_ctl(1, 0, 0, 1); repeat (60) @(negedge clk);
    chk("R9 still running", busy, 1);
    write_ctl(1, 0, 1, 7); repeat (90) @(negedge clk);
    write_ctl(1, 1, 0, 7); repeat (50) @(negedge clk);
    write_ctl(1, 1, 1, 4); repeat (120) @(negedge clk);
    chk("R9 seq_done held", seq_done, 1);
    // abort mid one-shot
    write_ctl(0, 1, 1, 0); repeat (7) @(negedge clk);
    write_ctl(0, 1, 0, 7); wait_idle();
    write_ctl(0, 0, 1, 0); repeat (2) @(negedge clk);
    write_ctl(0, 0, 0, 4); wait_idle();
    chk("R2 R7 flags after restart", reg_flag, 8'h0F);
    report();
  end
endmodule